// File: doc/BRIEF.md
# PWM Carrier Chopper

This stage breaks a slow PWM drive signal into a train of short pulses so that the drive can pass through a pulse transformer. While the PWM input is high, the output is the input gated by a square carrier. The carrier is built from eight equal phase steps. Each step lasts `car_prescale + 1` main clocks, and the carrier is high for the first `car_duty` steps of every period. The duty is therefore set in eighths.

A PWM rising edge resets the carrier to phase 0. The burst can then start with a wide first pulse that stays high for `first_width` whole carrier periods. A width of 0 leaves the first pulse out. Chopping runs from then on until the PWM input falls. The output is inactive whenever the input is low, and it can be inverted. With `chop_en` low the input passes straight to the output. The output is combinational from registered phase state and the live inputs, so a PWM edge reaches the output in the same cycle.

Top module: `pwm_chopper`

## Requirements
- R1: With `chop_en` = 0, `chop_out` equals `pwm_in` in every cycle, whatever the other settings are.
- R2: With `chop_en` = 1 and `pwm_in` = 0, `chop_out` equals `out_invert` (the inactive level).
- R3: One carrier phase step lasts `car_prescale + 1` clocks, and one carrier period is 8 steps. Counting k from 0 in the cycle where `pwm_in` rises, the step index is (k / (P+1)) mod 8 and the period index is k / (8(P+1)).
- R4: After the first pulse, the un-inverted output is high exactly when the step index is less than `car_duty`. A duty of 0 keeps it low.
- R5: On the cycle where `pwm_in` rises, the carrier restarts at step 0 and period 0, whatever the phase was before.
- R6: The un-inverted output is held high while the period index is less than `first_width`. With `first_width` = 0 there is no first pulse.
- R7: With `chop_en` = 1, `out_invert` = 1 complements the output level, both while chopping and while idle.
- R8: Chopping continues for as long as `pwm_in` stays high. A falling `pwm_in` returns the output to the inactive level in that same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Main clock |
| rst | input | 1 | Synchronous active-high reset |
| pwm_in | input | 1 | PWM signal to be chopped |
| chop_en | input | 1 | 1: chopped output, 0: pass-through |
| car_prescale | input | 4 | Clocks per carrier step, minus one |
| car_duty | input | 3 | Carrier high steps per period (eighths) |
| first_width | input | 4 | First pulse length in carrier periods, 0 = none |
| out_invert | input | 1 | Invert the chopped output |
| chop_out | output | 1 | Modulated output |

## Verification
Four behaviours are checked on every cycle: pass-through when disabled, the inactive level while the input is low, a high output on the rising-edge cycle when a first pulse or a non-zero duty is set, and a constant inactive level when both duty and first width are zero. Step length, duty placement, the length of the first pulse and the restart of the phase can only be seen over whole bursts. The bench sweeps prescale, duty, first width and polarity, and compares every cycle of each burst with a value computed from the cycle count since the rising edge.

// File: rtl/chop_pkg.sv
package chop_pkg;
    localparam int PRE_W  = 4;
    localparam int STEP_W = 3;
    localparam int OS_W   = 4;

    typedef struct packed {
        logic [PRE_W-1:0]  pre;
        logic [STEP_W-1:0] step;
    } chop_phase_t;

    function automatic logic carrier_high(input logic [STEP_W-1:0] step,
                                          input logic [STEP_W-1:0] duty);
        return step < duty;
    endfunction
endpackage

// File: rtl/chop_phase_div.sv
module chop_phase_div
    import chop_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             resync,
    input  logic [PRE_W-1:0] prescale,
    output logic [STEP_W-1:0] step,
    output logic             period_end
);
    chop_phase_t cur_q, eff, nxt;
    logic        tick;

    always_comb begin
        eff = resync ? '0 : cur_q;
        tick = (eff.pre >= prescale);
        nxt.pre  = tick ? '0 : eff.pre + 1'b1;
        nxt.step = tick ? eff.step + 1'b1 : eff.step;
    end

    assign step       = eff.step;
    assign period_end = tick && (eff.step == '1);

    always_ff @(posedge clk) begin
        if (rst) cur_q <= '0;
        else     cur_q <= nxt;
    end
endmodule

// File: rtl/chop_first_pulse.sv
module chop_first_pulse
    import chop_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic            resync,
    input  logic            period_end,
    input  logic [OS_W-1:0] width,
    output logic            active
);
    logic [OS_W-1:0] cnt_q, cnt_eff;

    assign cnt_eff = resync ? '0 : cnt_q;
    assign active  = cnt_eff < width;

    always_ff @(posedge clk) begin
        if (rst)
            cnt_q <= '0;
        else if (period_end && cnt_eff != '1)
            cnt_q <= cnt_eff + 1'b1;
        else
            cnt_q <= cnt_eff;
    end
endmodule

// File: rtl/chop_out_stage.sv
module chop_out_stage
    import chop_pkg::*;
(
    input  logic              en,
    input  logic              pwm,
    input  logic              first,
    input  logic [STEP_W-1:0] step,
    input  logic [STEP_W-1:0] duty,
    input  logic              invert,
    output logic              y
);
    logic gated;

    always_comb begin
        gated = pwm && (first || carrier_high(step, duty));
        y     = en ? (gated ^ invert) : pwm;
    end
endmodule

// File: rtl/pwm_chopper.sv
module pwm_chopper
    import chop_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              pwm_in,
    input  logic              chop_en,
    input  logic [PRE_W-1:0]  car_prescale,
    input  logic [STEP_W-1:0] car_duty,
    input  logic [OS_W-1:0]   first_width,
    input  logic              out_invert,
    output logic              chop_out
);
    logic              pwm_q;
    logic              rise;
    logic [STEP_W-1:0] step;
    logic              period_end;
    logic              first_on;

    always_ff @(posedge clk) begin
        if (rst) pwm_q <= 1'b0;
        else     pwm_q <= pwm_in;
    end

    assign rise = pwm_in && !pwm_q;

    chop_phase_div u_div (
        .clk(clk), .rst(rst), .resync(rise), .prescale(car_prescale),
        .step(step), .period_end(period_end)
    );

    chop_first_pulse u_first (
        .clk(clk), .rst(rst), .resync(rise), .period_end(period_end),
        .width(first_width), .active(first_on)
    );

    chop_out_stage u_out (
        .en(chop_en), .pwm(pwm_in), .first(first_on), .step(step),
        .duty(car_duty), .invert(out_invert), .y(chop_out)
    );
endmodule

// File: rtl/pwm_chopper_chk.sv
module pwm_chopper_chk
    import chop_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              pwm_in,
    input logic              chop_en,
    input logic [STEP_W-1:0] car_duty,
    input logic [OS_W-1:0]   first_width,
    input logic              out_invert,
    input logic              chop_out
);
    logic pwm_seen;

    always_ff @(posedge clk) begin
        if (rst) pwm_seen <= 1'b0;
        else     pwm_seen <= pwm_in;
    end

    p_bypass_r1: assert property (@(posedge clk) disable iff (rst)
        !chop_en |-> chop_out == pwm_in);

    p_idle_level_r2: assert property (@(posedge clk) disable iff (rst)
        (chop_en && !pwm_in) |-> chop_out == out_invert);

    p_rise_active_r5: assert property (@(posedge clk) disable iff (rst)
        (chop_en && pwm_in && !pwm_seen && (first_width != 0 || car_duty != 0))
        |-> chop_out == !out_invert);

    p_no_carrier_r4: assert property (@(posedge clk) disable iff (rst)
        (chop_en && car_duty == 0 && first_width == 0) |-> chop_out == out_invert);

    p_fall_inactive_r8: assert property (@(posedge clk) disable iff (rst)
        (chop_en && !pwm_in && pwm_seen) |-> chop_out == out_invert);
endmodule

bind pwm_chopper pwm_chopper_chk u_chk (
    .clk(clk), .rst(rst), .pwm_in(pwm_in), .chop_en(chop_en),
    .car_duty(car_duty), .first_width(first_width),
    .out_invert(out_invert), .chop_out(chop_out)
);

// File: tb/pwm_chopper_bench.sv
module pwm_chopper_bench;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       pwm_in = 1'b0;
    logic       chop_en = 1'b0;
    logic [3:0] car_prescale = '0;
    logic [2:0] car_duty = '0;
    logic [3:0] first_width = '0;
    logic       out_invert = 1'b0;
    logic       chop_out;

    int total = 0;
    int bad = 0;
    int cycles = 0;
    bit done = 0;

    always #5 clk = ~clk;

    pwm_chopper u_pwm_chopper (
        .clk(clk), .rst(rst), .pwm_in(pwm_in), .chop_en(chop_en),
        .car_prescale(car_prescale), .car_duty(car_duty),
        .first_width(first_width), .out_invert(out_invert),
        .chop_out(chop_out)
    );

    task automatic check(input string req, input logic exp);
        total++;
        if (chop_out !== exp) begin
            bad++;
            $display("FAIL %s: got %b expected %b (P=%0d D=%0d W=%0d inv=%0d en=%0d pwm=%0d)",
                     req, chop_out, exp, car_prescale, car_duty, first_width,
                     out_invert, chop_en, pwm_in);
        end
    endtask

    function automatic logic model(input int k, input int p, input int d,
                                   input int w, input int inv);
        int st = k / (p + 1);
        logic hi = ((st / 8) < w) || ((st % 8) < d);
        return hi ^ inv[0];
    endfunction

    // One burst: R3/R4/R5/R6/R7 inside, R8 at the fall, R2 while low.
    task automatic burst(input int p, input int d, input int w, input int inv,
                         input int gap);
        int len = 8 * (p + 1) * (w + 1) + 8 * (p + 1) + 3;
        @(negedge clk);
        car_prescale = p[3:0]; car_duty = d[2:0]; first_width = w[3:0];
        out_invert = inv[0]; chop_en = 1'b1;
        for (int g = 0; g < gap; g++) begin
            #1 check("R2", inv[0]);
            @(negedge clk);
        end
        pwm_in = 1'b1;
        for (int k = 0; k < len; k++) begin
            #1 check("R3_R4_R5_R6_R7", model(k, p, d, w, inv));
            @(negedge clk);
        end
        pwm_in = 1'b0;
        #1 check("R8", inv[0]);
        @(negedge clk);
        #1 check("R2", inv[0]);
    endtask

    initial begin
        forever begin
            @(posedge clk);
            cycles++;
            if (cycles > 190000 && !done) begin
                bad++;
                total++;
                done = 1;
                $display("FAIL watchdog: got timeout expected completion");
                $display("test done: total=%0d bad=%0d", total, bad);
                $finish;
            end
        end
    end

    initial begin
        // Reset: pass-through while disabled (R1)
        pwm_in = 1'b1;
        #1 check("R1", 1'b1);
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R1 sweep: disabled, settings ignored
        for (int i = 0; i < 16; i++) begin
            @(negedge clk);
            pwm_in = i[0]; car_duty = i[2:0]; first_width = i[3:0];
            out_invert = i[1]; car_prescale = i[3:0];
            #1 check("R1", i[0]);
        end
        @(negedge clk);
        pwm_in = 1'b0;
        // Main sweep
        for (int p = 0; p < 4; p++)
            for (int d = 0; d < 8; d++)
                for (int w = 0; w < 3; w++)
                    for (int inv = 0; inv < 2; inv++)
                        burst(p, d, w, inv, 1 + ((p + d + w) % 5));
        // R5: rise mid-carrier after a short low phase restarts at step 0
        burst(2, 3, 0, 0, 7);
        burst(2, 3, 1, 1, 2);
        // Large corners
        burst(15, 5, 15, 0, 3);
        burst(15, 7, 0, 1, 1);
        if (!done) begin
            done = 1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule